// File: doc/BRIEF.md
# CPU-Stop and Power-Down Output Clock Gating

This block sits between the free-running clock sources of a multi-output clock generator and the output pins. It decides on each cycle whether each output follows its source or is held off. It is built for an FPGA-style datapath. A fast sampling clock `clk` registers every source level and every output, so each output is a one-cycle-delayed, gated copy of its source. Two asynchronous active-low controls drive it. The first stops only the processor clock pair and the chipset copy of the processor clock. The second powers the whole block down. Per-output enable bits from the control registers add a static gate to each output.

Every enable change takes effect only while the source concerned is low. An output therefore never shows a shortened high pulse. Stopping is deferred by a small, fixed number of processor cycles and counted from a rising edge of a chosen peripheral (PCI) source. The processor output ends on a falling edge and restarts with a rising edge. The complementary processor output has its own output-enable. It is released instead of driven low, and while enabled it is always the inverse of the true output.

During power-down the block waits until every output has come to rest low. It then drops `osc_en`, which the internal sources use as their run permission.

Top module: `clkgate_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all clock outputs are 0, `cpu_clk_n_oe` is 0 and `osc_en` is 1.
- R2: A cleared `cpu_en` holds `cpu_clk` at 0 and `cpu_clk_n_oe` at 0. A cleared `cs_en` holds `cpu_cs_clk` at 0. A cleared bit i of `periph_en` holds `periph_clk[i]` at 0. A set bit lets the output follow its source.
- R3: While `cpu_stop_n` is 0 and `pwr_dn_n` is 1, `cpu_clk` and `cpu_cs_clk` come to rest at 0 and `cpu_clk_n_oe` at 0. The enabled peripheral outputs and `osc_en` = 1 are unaffected.
- R4: Both controls pass a two-flop synchroniser. A stop request is accepted at the first rising edge of `periph_src[PCI_IDX]` that sees it. From that edge the processor outputs show exactly LAT further rising edges, one per processor source rising edge, and then stay low.
- R5: A release is accepted at the first rising edge of `periph_src[PCI_IDX]` that sees it. The next LAT processor source rising edges are skipped. `cpu_clk_n_oe` then rises with `cpu_clk_n` = 1 and `cpu_clk` = 0, and on the next cycle `cpu_clk` rises.
- R6: An output rises only one cycle after its source was sampled high and falls only one cycle after it was sampled low. Every high run of an output is as long as the whole high run of its source.
- R7: Whenever `cpu_clk_n_oe` is 1, `cpu_clk_n` is the inverse of `cpu_clk`.
- R8: While `pwr_dn_n` is 0, every clock output is held at 0 and `cpu_clk_n_oe` at 0, whatever `cpu_stop_n` and the enable bits are. `osc_en` falls only once every output has stopped. `osc_en` returns to 1 after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than every source |
| rst | input | 1 | Synchronous active-high reset |
| cpu_stop_n | input | 1 | Asynchronous active-low processor clock stop |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down |
| cpu_en | input | 1 | Register enable for the processor pair |
| cs_en | input | 1 | Register enable for the chipset copy |
| periph_en | input | NP | Register enables for the peripheral outputs |
| cpu_src | input | 1 | Free-running processor source level |
| periph_src | input | NP | Free-running peripheral source levels |
| cpu_clk | output | 1 | Gated processor clock |
| cpu_cs_clk | output | 1 | Gated chipset copy of the processor clock |
| cpu_clk_n | output | 1 | Complementary processor clock data |
| cpu_clk_n_oe | output | 1 | Output-enable of the complementary clock |
| periph_clk | output | NP | Gated peripheral clocks |
| osc_en | output | 1 | Run permission for the internal sources |

## Verification
The edge-coincidence assertions take for granted that every source holds each level for at least one `clk` cycle. They also assume a source restarts only from its low phase after `osc_en` returns. The bench derives every source from one counter at sub-multiples of `clk`. It re-enables its sources only at a counter phase where all of them are low. The stop and release controls are changed well clear of the PCI edge that must accept them, so the synchroniser delay never moves the acceptance edge.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN      = 2'd0,
    SEQ_STOPPING = 2'd1,
    SEQ_STOPPED  = 2'd2,
    SEQ_STARTING = 2'd3
  } seq_state_e;

  // counter width able to hold 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter int              W       = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/clkgate_stop_seq.sv
module clkgate_stop_seq #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic cpu_src,
  input  logic ref_src,
  output logic run_req
);
  import clkgate_pkg::*;

  localparam int unsigned CW = cnt_width(LAT);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          cpu_d_q;
  logic          ref_d_q;
  logic          cpu_rise;
  logic          ref_rise;

  assign cpu_rise = cpu_src & ~cpu_d_q;
  assign ref_rise = ref_src & ~ref_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_RUN;
      cnt_q   <= '0;
      cpu_d_q <= 1'b0;
      ref_d_q <= 1'b0;
    end else begin
      cpu_d_q <= cpu_src;
      ref_d_q <= ref_src;
      case (state_q)
        SEQ_RUN: begin
          if (ref_rise && stop_req) begin
            state_q <= SEQ_STOPPING;
            cnt_q   <= '0;
          end
        end
        SEQ_STOPPING: begin
          if (!stop_req) begin
            state_q <= SEQ_RUN;
          end else if (cpu_rise) begin
            if (cnt_q == LAST) state_q <= SEQ_STOPPED;
            else               cnt_q   <= cnt_q + 1'b1;
          end
        end
        SEQ_STOPPED: begin
          if (ref_rise && !stop_req) begin
            state_q <= SEQ_STARTING;
            cnt_q   <= '0;
          end
        end
        default: begin
          if (stop_req) begin
            state_q <= SEQ_STOPPED;
          end else if (cpu_rise) begin
            if (cnt_q == LAST) state_q <= SEQ_RUN;
            else               cnt_q   <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign run_req = (state_q == SEQ_RUN) || (state_q == SEQ_STOPPING);

  // R4: the processor clocks are only withdrawn while a stop is requested
  p_stop_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(run_req) |-> $past(stop_req));

  // R5: the processor clocks only come back once the request is gone
  p_start_needs_release_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(run_req) |-> !$past(stop_req));

endmodule

// File: rtl/clkgate_gate.sv
module clkgate_gate (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic req,
  output logic clk_o,
  output logic on
);

  logic en_q;
  logic out_q;

  // the enable moves only in the low phase of the source
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      if (!src) en_q <= req;
      out_q <= src & en_q;
    end
  end

  assign clk_o = out_q;
  assign on    = en_q;

  // R6: output edges line up with source levels
  p_rise_with_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_o) |-> $past(src));

  p_fall_with_src_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_o) |-> !$past(src));

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
  parameter int NP      = 8,
  parameter int PCI_IDX = 0,
  parameter int LAT     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_stop_n,
  input  logic          pwr_dn_n,
  input  logic          cpu_en,
  input  logic          cs_en,
  input  logic [NP-1:0] periph_en,
  input  logic          cpu_src,
  input  logic [NP-1:0] periph_src,
  output logic          cpu_clk,
  output logic          cpu_cs_clk,
  output logic          cpu_clk_n,
  output logic          cpu_clk_n_oe,
  output logic [NP-1:0] periph_clk,
  output logic          osc_en
);

  localparam int NCTL = 2;

  logic [NCTL-1:0] ctl_s;
  logic            stop_req;
  logic            pd_req;
  logic            run_req;
  logic            cpu_on;
  logic            cs_on;
  logic [NP-1:0]   per_on;
  logic            comp_q;
  logic            oe_q;
  logic            osc_q;

  clkgate_sync #(.W(NCTL), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cpu_stop_n, pwr_dn_n}),
    .q   (ctl_s)
  );

  assign stop_req = ~ctl_s[1];
  assign pd_req   = ~ctl_s[0];

  clkgate_stop_seq #(.LAT(LAT)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_req),
    .cpu_src  (cpu_src),
    .ref_src  (periph_src[PCI_IDX]),
    .run_req  (run_req)
  );

  clkgate_gate u_cpu (
    .clk   (clk),
    .rst   (rst),
    .src   (cpu_src),
    .req   (run_req & cpu_en & ~pd_req),
    .clk_o (cpu_clk),
    .on    (cpu_on)
  );

  clkgate_gate u_cs (
    .clk   (clk),
    .rst   (rst),
    .src   (cpu_src),
    .req   (run_req & cs_en & ~pd_req),
    .clk_o (cpu_cs_clk),
    .on    (cs_on)
  );

  for (genvar g = 0; g < NP; g++) begin : g_per
    clkgate_gate u_per (
      .clk   (clk),
      .rst   (rst),
      .src   (periph_src[g]),
      .req   (periph_en[g] & ~pd_req),
      .clk_o (periph_clk[g]),
      .on    (per_on[g])
    );
  end

  // complementary output shares the processor gate's enable
  always_ff @(posedge clk) begin
    if (rst) begin
      comp_q <= 1'b0;
      oe_q   <= 1'b0;
      osc_q  <= 1'b1;
    end else begin
      comp_q <= ~cpu_src & cpu_on;
      oe_q   <= cpu_on;
      osc_q  <= !(pd_req && !(cpu_on || cs_on || (|per_on)));
    end
  end

  assign cpu_clk_n    = comp_q;
  assign cpu_clk_n_oe = oe_q;
  assign osc_en       = osc_q;

  // R7: driven complement is always the inverse of the true output
  p_comp_inverse_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_n_oe |-> (cpu_clk_n != cpu_clk));

  // R8: sources are only released once everything is quiet
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!cpu_clk && !cpu_cs_clk && !cpu_clk_n_oe && (periph_clk == '0)));

  // R3: a stopped processor pair never drives the complement
  p_pair_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_n_oe && $past(!cpu_clk_n_oe)) |-> !cpu_clk);

endmodule

// File: tb/clkgate_ctrl_tb.sv
module clkgate_ctrl_tb;

  localparam int CLK_P   = 10;
  localparam int NP      = 8;
  localparam int LAT     = 2;
  localparam int CPU_HI  = 2;
  localparam int PCI_HI  = 8;
  localparam int NVEC    = 8;

  typedef struct packed {
    logic          cpu_en;
    logic          cs_en;
    logic          stop_n;
    logic          pd_n;
    logic [NP-1:0] pen;
    logic          e_cpu;
    logic          e_cs;
    logic [NP-1:0] e_per;
    logic          e_osc;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 8'hFF, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1, 8'hFF, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 8'hA5, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 8'hFF, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b1, 8'h5A, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_stop_n = 1'b1;
  logic          pwr_dn_n = 1'b1;
  logic          cpu_en = 1'b1;
  logic          cs_en = 1'b1;
  logic [NP-1:0] periph_en = '1;
  logic          cpu_src;
  logic [NP-1:0] periph_src;
  logic          cpu_clk;
  logic          cpu_cs_clk;
  logic          cpu_clk_n;
  logic          cpu_clk_n_oe;
  logic [NP-1:0] periph_clk;
  logic          osc_en;

  logic [15:0]   cyc = '0;
  logic          src_on = 1'b1;
  int            n_chk = 0;
  int            n_err = 0;
  int            cpu_run = 0;
  int            pci_run = 0;
  logic          runt_seen = 1'b0;
  logic          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // sources: counter bits, restarted only where all of them are low
  always @(negedge clk) begin
    cyc <= cyc + 16'd1;
    if (!osc_en) src_on <= 1'b0;
    else if (cyc[3:0] == 4'd15) src_on <= 1'b1;
  end

  assign cpu_src = src_on & cyc[1];
  always_comb begin
    for (int i = 0; i < NP; i++) periph_src[i] = src_on & cyc[3 - (i % 3)];
  end

  // R6 monitor: every high run must be a whole source high run
  always @(negedge clk) begin
    if (!rst) begin
      if (cpu_clk) cpu_run <= cpu_run + 1;
      else begin
        if (cpu_run != 0 && cpu_run != CPU_HI) runt_seen <= 1'b1;
        cpu_run <= 0;
      end
      if (periph_clk[0]) pci_run <= pci_run + 1;
      else begin
        if (pci_run != 0 && pci_run != PCI_HI) runt_seen <= 1'b1;
        pci_run <= 0;
      end
    end
  end

  clkgate_ctrl #(.NP(NP), .PCI_IDX(0), .LAT(LAT)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .cpu_stop_n   (cpu_stop_n),
    .pwr_dn_n     (pwr_dn_n),
    .cpu_en       (cpu_en),
    .cs_en        (cs_en),
    .periph_en    (periph_en),
    .cpu_src      (cpu_src),
    .periph_src   (periph_src),
    .cpu_clk      (cpu_clk),
    .cpu_cs_clk   (cpu_cs_clk),
    .cpu_clk_n    (cpu_clk_n),
    .cpu_clk_n_oe (cpu_clk_n_oe),
    .periph_clk   (periph_clk),
    .osc_en       (osc_en)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_phase9();
    step();
    while (cyc[3:0] != 4'd9) step();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int p;
    int cnt;
    int cs_cnt;
    int last;
    int first_oe;
    int first_rise;
    logic prev;
    logic prev_cs;
    logic per_tog;

    // R1 reset state
    repeat (4) step();
    chk("R1 outputs in reset", {cpu_clk, cpu_cs_clk, cpu_clk_n_oe, |periph_clk}, 4'b0000);
    chk("R1 osc_en in reset", osc_en, 1'b1);
    rst = 1'b0;
    step();
    chk("R1 outputs after reset", {cpu_clk, cpu_cs_clk, cpu_clk_n_oe, |periph_clk}, 4'b0000);
    repeat (40) step();

    // table walk: R2 R3 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      logic          t_cpu, t_cs, o_cpu, o_cs, oe_or, oe_and, osc_or, osc_and, comp_bad;
      logic [NP-1:0] t_per, o_per, p_per;
      logic          p_cpu, p_cs;
      cpu_en     = VECS[v].cpu_en;
      cs_en      = VECS[v].cs_en;
      cpu_stop_n = VECS[v].stop_n;
      pwr_dn_n   = VECS[v].pd_n;
      periph_en  = VECS[v].pen;
      repeat (64 + (v % 3)) step();
      t_cpu = 0; t_cs = 0; t_per = '0; o_cpu = 0; o_cs = 0; o_per = '0;
      oe_or = 0; oe_and = 1; osc_or = 0; osc_and = 1; comp_bad = 0;
      p_cpu = cpu_clk; p_cs = cpu_cs_clk; p_per = periph_clk;
      for (int k = 0; k < 48; k++) begin
        step();
        t_cpu |= (cpu_clk != p_cpu);
        t_cs  |= (cpu_cs_clk != p_cs);
        t_per |= (periph_clk ^ p_per);
        o_cpu |= cpu_clk; o_cs |= cpu_cs_clk; o_per |= periph_clk;
        oe_or |= cpu_clk_n_oe; oe_and &= cpu_clk_n_oe;
        osc_or |= osc_en; osc_and &= osc_en;
        if (cpu_clk_n_oe && (cpu_clk_n == cpu_clk)) comp_bad = 1;
        p_cpu = cpu_clk; p_cs = cpu_cs_clk; p_per = periph_clk;
      end
      chk($sformatf("R2 R3 R8 vec%0d cpu_clk", v), VECS[v].e_cpu ? t_cpu : o_cpu, VECS[v].e_cpu);
      chk($sformatf("R2 R3 R8 vec%0d cpu_cs_clk", v), VECS[v].e_cs ? t_cs : o_cs, VECS[v].e_cs);
      chk($sformatf("R2 R3 R8 vec%0d periph_clk", v),
          (t_per & VECS[v].e_per) | (o_per & ~VECS[v].e_per), VECS[v].e_per);
      chk($sformatf("R2 R3 R8 vec%0d cpu_clk_n_oe", v), {oe_or, oe_and}, {2{VECS[v].e_cpu}});
      chk($sformatf("R8 vec%0d osc_en", v), {osc_or, osc_and}, {2{VECS[v].e_osc}});
      chk($sformatf("R7 vec%0d complement", v), comp_bad, 1'b0);
    end

    // R4 stop latency from the PCI source edge
    cpu_en = 1; cs_en = 1; periph_en = '1; cpu_stop_n = 1; pwr_dn_n = 1;
    repeat (64) step();
    wait_phase9();
    cpu_stop_n = 1'b0;
    p = int'(cyc) + 15;
    cnt = 0; cs_cnt = 0; last = -1; per_tog = 0;
    prev = cpu_clk; prev_cs = cpu_cs_clk;
    for (int k = 0; k < 80; k++) begin
      logic pp;
      pp = periph_clk[0];
      step();
      if (cpu_clk && !prev && int'(cyc) >= p + 1) begin cnt++; last = int'(cyc); end
      if (cpu_cs_clk && !prev_cs && int'(cyc) >= p + 1) cs_cnt++;
      if (periph_clk[0] != pp) per_tog = 1;
      prev = cpu_clk; prev_cs = cpu_cs_clk;
    end
    chk("R4 cpu_clk pulses after PCI edge", cnt, LAT);
    chk("R4 cpu_cs_clk pulses after PCI edge", cs_cnt, LAT);
    chk("R4 last cpu_clk rise cycle", last, p + 3 + 4 * (LAT - 1));
    chk("R3 stopped pair state", {cpu_clk, cpu_cs_clk, cpu_clk_n_oe}, 3'b000);
    chk("R3 PCI output keeps running", per_tog, 1'b1);

    // R5 restart latency and complement ordering
    wait_phase9();
    cpu_stop_n = 1'b1;
    p = int'(cyc) + 15;
    first_oe = -1; first_rise = -1;
    for (int k = 0; k < 80; k++) begin
      step();
      if (first_oe < 0 && cpu_clk_n_oe) begin
        first_oe = int'(cyc);
        chk("R5 complement driven high first", {cpu_clk_n, cpu_clk}, 2'b10);
      end
      if (first_rise < 0 && cpu_clk) first_rise = int'(cyc);
    end
    chk("R5 first cpu_clk rise cycle", first_rise, p + 3 + 4 * LAT);
    chk("R5 complement enable one cycle ahead", first_oe, first_rise - 1);

    // R6 glitch-free over all of the above
    chk("R6 no shortened pulses", runt_seen, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule